// File: doc/BRIEF.md
# Integer multiply-divide unit

This block is an iterative integer multiply and divide engine that serves the multiply-divide instruction group of an integer core. It accepts two XLEN-bit operands and an operation code with a one-cycle `start_i` pulse. It then works through one operand bit per clock: shift-and-add for products, restoring subtract-and-shift for quotients. After a fixed number of cycles it raises `done_o` for one cycle together with one XLEN-bit result. Signed operands are turned into magnitudes before the loop, and the sign is put back afterwards. The same loop therefore serves the signed, mixed and unsigned forms of every operation.

When XLEN is 64, a word flag selects 32-bit operation for the low-product, divide and remainder codes. In that mode only the low 32 bits of each operand are used, and the 32-bit result is sign-extended to 64 bits. Division by zero and signed overflow return fixed values and raise no trap.

The controller has four states. `ST_IDLE` waits for work. `ST_RUN` performs the XLEN iterations. `ST_ADJ` applies the sign correction and picks the product half, quotient or remainder. `ST_FIN` applies the zero-divisor override and word-mode extension and registers the result. The transitions are:
- idle to run on an accepted start
- run to run while the iteration counter is below XLEN-1
- run to adjust after the last iteration
- adjust to finish
- finish to idle, which pulses `done_o`

Top module: `mdu_unit`

## Requirements
- R1: Operation codes are 0 low product, 1 high product signed×signed, 2 high product signed×unsigned, 3 high product unsigned×unsigned, 4 signed quotient, 5 unsigned quotient, 6 signed remainder, 7 unsigned remainder. Code 0 returns the low XLEN bits of `opa_i`×`opb_i`.
- R2: Codes 1, 2 and 3 return bits [2·XLEN-1:XLEN] of the full product, with the signedness of each operand given by the code (code 2 treats `opa_i` as signed and `opb_i` as unsigned).
- R3: Code 4 returns the signed quotient truncated toward zero; code 5 returns the unsigned quotient.
- R4: Code 6 returns the signed remainder, which is zero or carries the sign of the dividend; code 7 returns the unsigned remainder.
- R5: With a zero divisor, codes 4 and 5 return all ones and codes 6 and 7 return the dividend.
- R6: For code 4 or 6 with the most negative dividend and a divisor of -1, the quotient equals the dividend and the remainder is zero.
- R7: With XLEN 64 and `word_i` high, codes 0, 4, 5, 6 and 7 operate on the low 32 bits of each operand, sign- or zero-extended as the code requires, and return the 32-bit result sign-extended to 64 bits. For codes 1 to 3, `word_i` has no effect.
- R8: `done_o` is high for exactly one cycle, XLEN+2 rising edges after the edge that accepted start. `busy_o` is high from the accepting edge until that edge, and low while `done_o` is high.
- R9: A start while `busy_o` is high is ignored, and operands changed after acceptance have no effect. `result_o` keeps its value except on the edge that raises `done_o`.
- R10: After reset, `busy_o` and `done_o` are low and `result_o` is zero.
- R11: A start given in the cycle where `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when not busy |
| op_i | input | 3 | Operation code (see R1) |
| word_i | input | 1 | 32-bit word mode (XLEN 64 only) |
| opa_i | input | XLEN | First operand / dividend |
| opb_i | input | XLEN | Second operand / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result valid pulse |
| result_o | output | XLEN | Result, held until the next done |

## Verification
The result pulse of one operation and the acceptance of the next start can fall in the same cycle, because `busy_o` is already low while `done_o` is high. The bench's driver waits only for `busy_o` to drop, so every operation after the first is issued in the done cycle of the previous one. This exercises the finish-to-idle transition together with the idle-to-run transition. The scoreboard then checks that each result still matches its own operands, that no result is lost or duplicated, and that the latency from every such start stays at XLEN+2 edges.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_MULH   = 3'd1,
        OP_MULHSU = 3'd2,
        OP_MULHU  = 3'd3,
        OP_DIV    = 3'd4,
        OP_DIVU   = 3'd5,
        OP_REM    = 3'd6,
        OP_REMU   = 3'd7
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ADJ  = 2'd2,
        ST_FIN  = 2'd3
    } mdu_state_e;

    // codes 4..7 go through the divider
    function automatic logic op_is_div(input logic [2:0] op);
        return op[2];
    endfunction

    // codes 1..3 select the upper product half
    function automatic logic op_is_high(input logic [2:0] op);
        return (op[2] == 1'b0) && (op[1:0] != 2'b00);
    endfunction

    function automatic logic op_is_rem(input logic [2:0] op);
        return op[2] & op[1];
    endfunction

    function automatic logic op_sgn_a(input logic [2:0] op);
        return (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
    endfunction

    function automatic logic op_sgn_b(input logic [2:0] op);
        return (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
    endfunction

endpackage

// File: rtl/mdu_fsm.sv
module mdu_fsm
    import mdu_pkg::*;
#(
    parameter int unsigned STEPS = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic adj_o,
    output logic fin_o,
    output logic busy_o
);

    localparam int unsigned CW = $clog2(STEPS + 1);

    mdu_state_e    state_q;
    mdu_state_e    state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == CW'(STEPS - 1)) state_d = ST_ADJ;
            ST_ADJ:  state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // iteration counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_o) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        adj_o  = 1'b0;
        fin_o  = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i;
            end
            ST_RUN:  step_o = 1'b1;
            ST_ADJ:  adj_o  = 1'b1;
            ST_FIN:  fin_o  = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // R8: adjustment only follows a complete run of iterations
    p_full_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ADJ) |-> (cnt_q == CW'(STEPS)));

    // R9: once busy, nothing but the finish state releases the unit
    p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (state_q != ST_FIN)) |=> busy_o);

endmodule

// File: rtl/mdu_prep.sv
module mdu_prep
    import mdu_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [2:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] a_ext_o,
    output logic [XLEN-1:0] a_mag_o,
    output logic [XLEN-1:0] b_mag_o,
    output logic            a_neg_o,
    output logic            b_neg_o,
    output logic            b_zero_o,
    output logic            word_o
);

    localparam bit WORD_OK = (XLEN > 32);

    logic            sgn_a;
    logic            sgn_b;
    logic [XLEN-1:0] b_ext;

    function automatic logic [XLEN-1:0] ext32(input logic [XLEN-1:0] v, input logic sgn);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = (i < 32) ? v[i] : (sgn & v[31]);
        end
        return r;
    endfunction

    always_comb begin
        sgn_a  = op_sgn_a(op_i);
        sgn_b  = op_sgn_b(op_i);
        word_o = WORD_OK && word_i && !op_is_high(op_i);
        if (word_o) begin
            a_ext_o = ext32(a_i, sgn_a);
            b_ext   = ext32(b_i, sgn_b);
        end else begin
            a_ext_o = a_i;
            b_ext   = b_i;
        end
        a_neg_o  = sgn_a & a_ext_o[XLEN-1];
        b_neg_o  = sgn_b & b_ext[XLEN-1];
        a_mag_o  = a_neg_o ? (~a_ext_o + 1'b1) : a_ext_o;
        b_mag_o  = b_neg_o ? (~b_ext + 1'b1) : b_ext;
        b_zero_o = (b_ext == '0);
    end

endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
    parameter int unsigned XLEN = 64
) (
    input  logic            div_i,
    input  logic [XLEN-1:0] hi_i,
    input  logic [XLEN-1:0] lo_i,
    input  logic [XLEN-1:0] opnd_i,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);

    logic [XLEN:0]   sum;
    logic [XLEN:0]   shifted;
    logic [XLEN-1:0] addend;
    logic [XLEN-1:0] trial;
    logic            fits;

    always_comb begin
        // shift-add: low half holds the remaining multiplier bits
        addend  = lo_i[0] ? opnd_i : {XLEN{1'b0}};
        sum     = {1'b0, hi_i} + {1'b0, addend};
        // restoring divide: bring the next dividend bit into the partial remainder
        shifted = {hi_i, lo_i[XLEN-1]};
        fits    = (shifted >= {1'b0, opnd_i});
        trial   = shifted[XLEN-1:0] - opnd_i;
        if (div_i) begin
            hi_o = fits ? trial : shifted[XLEN-1:0];
            lo_o = {lo_i[XLEN-2:0], fits};
        end else begin
            hi_o = sum[XLEN:1];
            lo_o = {sum[0], lo_i[XLEN-1:1]};
        end
    end

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
    import mdu_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);

    localparam int unsigned PW = 2 * XLEN;

    logic load, step, adj, fin;

    logic [XLEN-1:0] a_ext, a_mag, b_mag;
    logic            a_neg, b_neg, b_zero, word_eff;

    logic [2:0]      op_q;
    logic            word_q, a_neg_q, b_neg_q, b_zero_q;
    logic [XLEN-1:0] dvd_q, opnd_q, hi_q, lo_q, res_q, result_q;
    logic            done_q;

    logic [XLEN-1:0] hi_nx, lo_nx;
    logic [PW-1:0]   prod, prod_s;
    logic [XLEN-1:0] quo_s, rem_s, adj_val, raw, fin_val;

    mdu_fsm #(.STEPS(XLEN)) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(start_i),
        .load_o (load),
        .step_o (step),
        .adj_o  (adj),
        .fin_o  (fin),
        .busy_o (busy_o)
    );

    mdu_prep #(.XLEN(XLEN)) u_prep (
        .op_i    (op_i),
        .word_i  (word_i),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .a_ext_o (a_ext),
        .a_mag_o (a_mag),
        .b_mag_o (b_mag),
        .a_neg_o (a_neg),
        .b_neg_o (b_neg),
        .b_zero_o(b_zero),
        .word_o  (word_eff)
    );

    mdu_step #(.XLEN(XLEN)) u_step (
        .div_i (op_is_div(op_q)),
        .hi_i  (hi_q),
        .lo_i  (lo_q),
        .opnd_i(opnd_q),
        .hi_o  (hi_nx),
        .lo_o  (lo_nx)
    );

    function automatic logic [XLEN-1:0] sext32(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = (i < 32) ? v[i] : v[31];
        end
        return r;
    endfunction

    // sign correction and selection (adjust state)
    always_comb begin
        prod   = {hi_q, lo_q};
        prod_s = (a_neg_q ^ b_neg_q) ? (~prod + 1'b1) : prod;
        quo_s  = (a_neg_q ^ b_neg_q) ? (~lo_q + 1'b1) : lo_q;
        rem_s  = a_neg_q ? (~hi_q + 1'b1) : hi_q;
        if (!op_is_div(op_q)) begin
            adj_val = (op_q == OP_MUL) ? prod_s[XLEN-1:0] : prod_s[PW-1:XLEN];
        end else if (op_is_rem(op_q)) begin
            adj_val = rem_s;
        end else begin
            adj_val = quo_s;
        end
    end

    // zero-divisor override and word extension (finish state)
    always_comb begin
        raw = res_q;
        if (op_is_div(op_q) && b_zero_q) begin
            raw = op_is_rem(op_q) ? dvd_q : {XLEN{1'b1}};
        end
        fin_val = word_q ? sext32(raw) : raw;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            op_q     <= '0;
            word_q   <= 1'b0;
            a_neg_q  <= 1'b0;
            b_neg_q  <= 1'b0;
            b_zero_q <= 1'b0;
            dvd_q    <= '0;
            opnd_q   <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            res_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= fin;
            if (load) begin
                op_q     <= op_i;
                word_q   <= word_eff;
                a_neg_q  <= a_neg;
                b_neg_q  <= b_neg;
                b_zero_q <= b_zero;
                dvd_q    <= a_ext;
                opnd_q   <= b_mag;
                hi_q     <= '0;
                lo_q     <= a_mag;
            end
            if (step) begin
                hi_q <= hi_nx;
                lo_q <= lo_nx;
            end
            if (adj) begin
                res_q <= adj_val;
            end
            if (fin) begin
                result_q <= fin_val;
            end
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;

    // R8: the result strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R8: the unit is free while the result is presented
    p_done_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R9: the result only moves with the strobe
    p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    // R5: a zero divisor yields an all-ones quotient
    p_div_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin && op_is_div(op_q) && !op_is_rem(op_q) && b_zero_q) |=> (result_o == {XLEN{1'b1}}));

endmodule

// File: tb/test_mdu_unit.sv
`timescale 1ns/1ps
module test_mdu_unit;

    localparam int XLEN = 64;
    localparam int LAT  = XLEN + 3; // negedge-to-negedge cycles from driving start to seeing done

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [2:0]      op = 3'd0;
    logic            word = 1'b0;
    logic [XLEN-1:0] a = '0;
    logic [XLEN-1:0] b = '0;
    logic            busy, done;
    logic [XLEN-1:0] result;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int b2b   = 0;

    logic [XLEN-1:0] exp_q[$];
    string           tag_q[$];
    int              t_q[$];

    logic [XLEN-1:0] last_res = '0;
    bit              moved = 1'b0;
    bit              prev_done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    mdu_unit #(.XLEN(XLEN)) i_mdu_unit (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .op_i    (op),
        .word_i  (word),
        .opa_i   (a),
        .opb_i   (b),
        .busy_o  (busy),
        .done_o  (done),
        .result_o(result)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // reference model at double width
    function automatic logic [63:0] model(input logic [2:0] o, input logic w, input logic [63:0] x, input logic [63:0] y);
        logic [127:0] xa, xb, p;
        logic [63:0] r;
        logic [31:0] r32, x32, y32;
        logic signed [31:0] s32a, s32b;
        logic signed [63:0] s64a, s64b;
        logic wm, sa, sb, ovf32, ovf64;
        wm    = w && (o == 3'd0 || o[2]);
        x32   = x[31:0];
        y32   = y[31:0];
        s32a  = x[31:0];
        s32b  = y[31:0];
        s64a  = x;
        s64b  = y;
        ovf32 = (x32 == 32'h8000_0000) && (y32 == 32'hffff_ffff);
        ovf64 = (x == 64'h8000_0000_0000_0000) && (y == 64'hffff_ffff_ffff_ffff);
        r = '0;
        if (!o[2]) begin
            if (wm) begin
                r32 = x32 * y32;
                r = sx32(r32);
            end else begin
                sa = (o == 3'd1) || (o == 3'd2);
                sb = (o == 3'd1);
                xa = sa ? {{64{x[63]}}, x} : {64'b0, x};
                xb = sb ? {{64{y[63]}}, y} : {64'b0, y};
                p  = xa * xb;
                r  = (o == 3'd0) ? p[63:0] : p[127:64];
            end
        end else if (wm) begin
            case (o)
                3'd4: r32 = (y32 == 0) ? 32'hffff_ffff : (ovf32 ? x32 : 32'(s32a / s32b));
                3'd5: r32 = (y32 == 0) ? 32'hffff_ffff : x32 / y32;
                3'd6: r32 = (y32 == 0) ? x32 : (ovf32 ? 32'd0 : 32'(s32a % s32b));
                default: r32 = (y32 == 0) ? x32 : x32 % y32;
            endcase
            r = sx32(r32);
        end else begin
            case (o)
                3'd4: r = (y == 0) ? '1 : (ovf64 ? x : 64'(s64a / s64b));
                3'd5: r = (y == 0) ? '1 : x / y;
                3'd6: r = (y == 0) ? x : (ovf64 ? 64'd0 : 64'(s64a % s64b));
                default: r = (y == 0) ? x : x % y;
            endcase
        end
        return r;
    endfunction

    function automatic string req_of(input logic [2:0] o, input logic w, input logic [63:0] x, input logic [63:0] y);
        logic wm;
        wm = w && (o == 3'd0 || o[2]);
        if (wm) return "R7";
        if (o[2] && y == 0) return "R5";
        if ((o == 3'd4 || o == 3'd6) && x == 64'h8000_0000_0000_0000 && y == '1) return "R6";
        if (o == 3'd0) return "R1";
        if (!o[2]) return "R2";
        if (!o[1]) return "R3";
        return "R4";
    endfunction

    // driver: issues one operation and pushes its expected result
    task automatic issue(input logic [2:0] o, input logic w, input logic [63:0] x, input logic [63:0] y);
        while (busy) @(negedge clk);
        if (done) b2b++;
        start = 1'b1;
        op    = o;
        word  = w;
        a     = x;
        b     = y;
        exp_q.push_back(model(o, w, x, y));
        tag_q.push_back(req_of(o, w, x, y));
        t_q.push_back(cyc);
        @(negedge clk);
        start = 1'b0;
        op    = ~o;
        a     = ~x;
        b     = y ^ 64'h5a5a;
        chk(busy == 1'b1, "R8 busy after accept", {63'b0, busy}, 64'd1);
    endtask

    // monitor: compares results with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!done && result !== last_res) moved = 1'b1;
            if (done) begin
                chk(!prev_done, "R8 done single pulse", {63'b0, prev_done}, 64'd0);
                chk(!moved, "R9 result held between strobes", result, last_res);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", result, '0);
                end else begin
                    logic [XLEN-1:0] e;
                    string tg;
                    int t0;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    t0 = t_q.pop_front();
                    chk(result === e, tg, result, e);
                    chk(cyc - t0 == LAT, "R8 latency", 64'(cyc - t0), 64'(LAT));
                end
                last_res = result;
                moved    = 1'b0;
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<190000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] cv[8];
        cv[0] = 64'd0;
        cv[1] = 64'd1;
        cv[2] = 64'hffff_ffff_ffff_ffff;
        cv[3] = 64'h8000_0000_0000_0000;
        cv[4] = 64'h7fff_ffff_ffff_ffff;
        cv[5] = 64'h0000_0000_8000_0000;
        cv[6] = 64'd7;
        cv[7] = 64'hffff_ffff_ffff_fff9;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0, "R10 busy", {63'b0, busy}, 64'd0);
        chk(done == 1'b0, "R10 done", {63'b0, done}, 64'd0);
        chk(result == '0, "R10 result", result, '0);

        // R3 R4: truncation toward zero and remainder sign
        issue(3'd4, 1'b0, cv[7], 64'd2);
        issue(3'd6, 1'b0, cv[7], 64'd2);
        issue(3'd6, 1'b0, 64'd7, 64'hffff_ffff_ffff_fffe);

        // R9: starts during busy are ignored
        issue(3'd0, 1'b0, 64'd12345, 64'd678);
        for (int k = 0; k < 3; k++) begin
            start = 1'b1;
            op    = 3'd5;
            a     = 64'(k + 99);
            b     = 64'd3;
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy == 1'b1, "R9 still busy after ignored starts", {63'b0, busy}, 64'd1);

        // corner operands for every code, both word settings (R1..R7)
        for (int w = 0; w < 2; w++) begin
            for (int o = 0; o < 8; o++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        issue(3'(o), w[0], cv[i], cv[j]);
                    end
                end
            end
        end

        // random operands
        for (int n = 0; n < 150; n++) begin
            issue(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                  {$urandom, $urandom}, (n % 5 == 0) ? 64'($urandom_range(0, 9)) : {$urandom, $urandom});
        end

        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 no lost results", 64'(exp_q.size()), 64'd0);
        chk(b2b > 0, "R11 back-to-back starts accepted", 64'(b2b), 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule